// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked design read and write one byte at a time in an external asynchronous static RAM of 2M words by 8 bits. A requester presents a single access on a valid/ready handshake with an address, a write byte and a direction flag. The controller then drives the memory's active-low select, output-enable and write strobes. It holds the address steady, and it drives the data pins through a separate output-enable signal. Each read returns its byte with a one-cycle response pulse.

Each analog timing figure of the memory is a parameter in picoseconds. At elaboration it becomes a whole number of system clocks by rounding up, with a floor of one cycle. After reset the controller stays busy for a supply settling interval of 1 ms by default. Writes keep output enable low and end on the write strobe. The memory needs time to release the pins after the write strobe falls, so the controller waits out that float time before it drives data. Between accesses the memory is deselected so that it draws standby current.

Top module: `asram_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly ceil(T_PWRUP_PS / CLK_PS) cycles. A request offered during that time is ignored: the select stays high and memory contents are unchanged.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the whole access, including recovery, is over. For a read that is RD cycles, and for a write it is FLT + DRV + REC cycles.
- R3: While idle and during reset, all three strobes are high (inactive) and `mem_dq_oe` is low.
- R4: A read holds select low, output enable low and write strobe high for RD = max(ceil(T_RC), ceil(T_AA), ceil(T_DOE)) cycles, with `mem_dq_oe` low throughout.
- R5: A read ends with `rsp_valid` high for exactly one cycle, carrying the byte present on `mem_dq_in` at the last edge of the read phase. This happens in the cycle `req_ready` returns high.
- R6: A write starts with select, write strobe and output enable all low and `mem_dq_oe` low for FLT = ceil(T_HZWE) cycles, so the memory's outputs can float.
- R7: The controller then drives the write byte for DRV = max(ceil(T_SD), ceil(T_PWE) − FLT, 1) cycles. As a result the data setup time and the write-strobe width are both met.
- R8: A write ends when select and write strobe rise on the same edge and `mem_dq_oe` drops on that edge. REC = ceil(T_LZWE) recovery cycles with all strobes high follow before the controller accepts again.
- R9: The address taken with the request is on `mem_addr` unchanged for every cycle the select is low.
- R10: The memory's data pins and the controller's data drivers are never both active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Byte read |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data toward the memory pins |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_in | input | DATA_W | Data from the memory pins |

## Verification
The timing figures are stretched so that every phase lasts a different number of cycles (3, 3, 4, 2). A wrong phase count or a swapped phase order therefore shows up as a distinct length. Directed cases cover the lowest and highest addresses, the bytes 00 and FF, a write followed straight away by a read of the same word, and a write offered during the power-up lockout. Those cases separate turnaround, hold-off and stale-data faults. Seeded random sequences mix reads and writes over a small address pool, so each word is written and read back repeatedly. A mismatch against the bench's reference memory then points to a lost write or a wrong address latch rather than to timing.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WFLOAT,
      ST_WDRIVE,
      ST_RECOVER
   } asram_state_e;

   // Round a time up to whole clocks.
   function automatic int unsigned ps_to_cyc(input longint unsigned t_ps,
                                             input int unsigned     clk_ps);
      return int'((t_ps + longint'(clk_ps) - 1) / longint'(clk_ps));
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned floor1(input int unsigned a);
      return (a == 0) ? 1 : a;
   endfunction

endpackage

// File: rtl/asram_lockout.sv
module asram_lockout #(
   parameter int unsigned HOLD_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   generate
      if (HOLD_CYC <= 1) begin : g_flop
         logic done_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) done_q <= 1'b0;
            else        done_q <= 1'b1;
         end
         assign done = done_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HOLD_CYC + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (cnt_q != CW'(HOLD_CYC))  cnt_q <= cnt_q + 1'b1;
         end
         assign done = (cnt_q == CW'(HOLD_CYC));
      end
   endgenerate
endmodule

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W      = 21,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CLK_PS      = 20000,
   parameter int unsigned T_PWRUP_PS  = 1000000000,
   parameter int unsigned T_RC_PS     = 12000,
   parameter int unsigned T_AA_PS     = 12000,
   parameter int unsigned T_DOE_PS    = 6000,
   parameter int unsigned T_PWE_PS    = 8000,
   parameter int unsigned T_SD_PS     = 6000,
   parameter int unsigned T_HZWE_PS   = 6000,
   parameter int unsigned T_LZWE_PS   = 3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   // Interval lengths in clocks
   localparam int unsigned PU_CYC  = floor1(ps_to_cyc(T_PWRUP_PS, CLK_PS));
   localparam int unsigned RD_CYC  = floor1(umax(ps_to_cyc(T_RC_PS, CLK_PS),
                                        umax(ps_to_cyc(T_AA_PS, CLK_PS),
                                             ps_to_cyc(T_DOE_PS, CLK_PS))));
   localparam int unsigned FLT_CYC = floor1(ps_to_cyc(T_HZWE_PS, CLK_PS));
   localparam int unsigned PWE_CYC = ps_to_cyc(T_PWE_PS, CLK_PS);
   localparam int unsigned PWE_REM = (PWE_CYC > FLT_CYC) ? PWE_CYC - FLT_CYC : 0;
   localparam int unsigned DRV_CYC = floor1(umax(ps_to_cyc(T_SD_PS, CLK_PS), PWE_REM));
   localparam int unsigned REC_CYC = floor1(ps_to_cyc(T_LZWE_PS, CLK_PS));
   localparam int unsigned MAX_CYC = umax(umax(RD_CYC, FLT_CYC), umax(DRV_CYC, REC_CYC));
   localparam int unsigned TW      = floor1($clog2(MAX_CYC + 1));

   initial begin
      assert (ADDR_W >= 1 && DATA_W >= 1) else $fatal(1, "asram_ctrl: bus widths must be nonzero");
      assert (CLK_PS >= 1) else $fatal(1, "asram_ctrl: clock period must be nonzero");
   end

   asram_state_e   state_q, state_d;
   logic           pu_done;
   logic           tmr_load, tmr_expired;
   logic [TW-1:0]  tmr_val;
   logic           accept;

   asram_lockout #(.HOLD_CYC(PU_CYC)) i_lockout (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pu_done)
   );

   asram_phase_timer #(.CW(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   assign req_ready = pu_done && (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (accept) begin
            tmr_load = 1'b1;
            if (req_write) begin
               state_d = ST_WFLOAT;
               tmr_val = TW'(FLT_CYC - 1);
            end else begin
               state_d = ST_READ;
               tmr_val = TW'(RD_CYC - 1);
            end
         end
         ST_READ: if (tmr_expired) state_d = ST_IDLE;
         ST_WFLOAT: if (tmr_expired) begin
            state_d  = ST_WDRIVE;
            tmr_load = 1'b1;
            tmr_val  = TW'(DRV_CYC - 1);
         end
         ST_WDRIVE: if (tmr_expired) begin
            state_d  = ST_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = TW'(REC_CYC - 1);
         end
         ST_RECOVER: if (tmr_expired) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   // Pin strobes are registered from the next state so they switch cleanly on the edge.
   logic sel_d, wr_d;
   assign sel_d = (state_d == ST_READ) || (state_d == ST_WFLOAT) || (state_d == ST_WDRIVE);
   assign wr_d  = (state_d == ST_WFLOAT) || (state_d == ST_WDRIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mem_ce_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
         mem_addr   <= '0;
         mem_dq_out <= '0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         state_q   <= state_d;
         mem_ce_n  <= !sel_d;
         mem_oe_n  <= !sel_d;
         mem_we_n  <= !wr_d;
         mem_dq_oe <= (state_d == ST_WDRIVE);
         if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
         rsp_valid <= (state_q == ST_READ) && tmr_expired;
         if ((state_q == ST_READ) && tmr_expired) rsp_rdata <= mem_dq_in;
      end
   end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int unsigned ADDR_W = 21,
   parameter int unsigned PU_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);
   int unsigned pu_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pu_cnt <= 0;
      else if (pu_cnt < PU_CYC)  pu_cnt <= pu_cnt + 1;
   end

   AST_LOCKOUT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_cnt < PU_CYC) |-> (!req_ready && mem_ce_n)); // R1
   AST_TAKE_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R2
   AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R3
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R5
   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_ce_n && !mem_oe_n && mem_we_n)); // R5
   AST_FLOAT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> $past(!mem_we_n && !mem_ce_n && !mem_dq_oe)); // R6
   AST_WRITE_END_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_ce_n && !mem_dq_oe)); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9
   AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !mem_oe_n && mem_we_n) |-> !mem_dq_oe); // R10
   AST_DRIVE_ONLY_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_ce_n && !mem_we_n)); // R10
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .PU_CYC(PU_CYC)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;
   localparam int unsigned AW     = 21;
   localparam int unsigned DW     = 8;
   localparam int unsigned CLK_PS = 20000;
   // Stretched figures so each phase has its own length
   localparam int unsigned P_RC   = 50000;
   localparam int unsigned P_AA   = 45000;
   localparam int unsigned P_DOE  = 25000;
   localparam int unsigned P_PWE  = 130000;
   localparam int unsigned P_SD   = 30000;
   localparam int unsigned P_HZWE = 50000;
   localparam int unsigned P_LZWE = 25000;
   localparam int unsigned P_PWR  = 1000000000;

   function automatic int cyc_of(input longint t);
      int c;
      c = int'((t + CLK_PS - 1) / CLK_PS);
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_PU  = cyc_of(P_PWR);
   localparam int E_RD  = imax(cyc_of(P_RC), imax(cyc_of(P_AA), cyc_of(P_DOE)));
   localparam int E_FLT = cyc_of(P_HZWE);
   localparam int E_DRV = imax(1, imax(cyc_of(P_SD), cyc_of(P_PWE) - E_FLT));
   localparam int E_REC = cyc_of(P_LZWE);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = '0;

   always #10 clk = ~clk;

   asram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .T_PWRUP_PS(P_PWR),
      .T_RC_PS(P_RC), .T_AA_PS(P_AA), .T_DOE_PS(P_DOE), .T_PWE_PS(P_PWE),
      .T_SD_PS(P_SD), .T_HZWE_PS(P_HZWE), .T_LZWE_PS(P_LZWE)
   ) i_asram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] blank_byte(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // Behavioural memory and an independent reference of expected contents
   logic [DW-1:0] model_mem [logic [AW-1:0]];
   logic [DW-1:0] ref_mem   [logic [AW-1:0]];
   logic [AW-1:0] cur_addr = '0;
   bit            ce_seen_low = 0;

   int  wr_cyc = 0, hz_cyc = 0, sd_cyc = 0, rd_cyc = 0;
   bit  prev_wr = 0, prev_rd = 0;
   logic [DW-1:0] w_byte = '0;
   logic [AW-1:0] w_addr = '0;

   always @(negedge clk) begin
      bit wr_act, rd_act, drv;
      if (rst_n) begin
         wr_act = !mem_ce_n && !mem_we_n;
         rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
         drv    = rd_act;
         if (!mem_ce_n) ce_seen_low = 1;
         if (drv && mem_dq_oe) check(0, "R10 contention", 1, 0);
         if (!mem_ce_n && mem_addr != cur_addr) check(0, "R9 address", mem_addr, cur_addr);
         if (wr_act) begin
            wr_cyc++;
            w_addr = mem_addr;
            if (mem_dq_oe) begin
               sd_cyc++;
               w_byte = mem_dq_out;
            end else if (sd_cyc == 0) hz_cyc++;
            else check(0, "R7 drive gap", 0, 1);
         end else if (prev_wr) begin
            check(hz_cyc == E_FLT, "R6 float cycles", hz_cyc, E_FLT);
            check(sd_cyc == E_DRV, "R7 drive cycles", sd_cyc, E_DRV);
            check(longint'(wr_cyc) * CLK_PS >= P_PWE && longint'(sd_cyc) * CLK_PS >= P_SD,
                  "R7 strobe width and setup", wr_cyc, E_FLT + E_DRV);
            check(mem_ce_n && !mem_dq_oe, "R8 joint end", {mem_ce_n, mem_dq_oe}, 2'b10);
            if (sd_cyc > 0) model_mem[w_addr] = w_byte;
            wr_cyc = 0; hz_cyc = 0; sd_cyc = 0;
         end
         if (rd_act) rd_cyc++;
         else if (prev_rd) begin
            check(rd_cyc == E_RD, "R4 read strobe cycles", rd_cyc, E_RD);
            rd_cyc = 0;
         end
         prev_wr = wr_act;
         prev_rd = rd_act;
         if (drv) mem_dq_in <= model_mem.exists(mem_addr) ? model_mem[mem_addr] : blank_byte(mem_addr);
         else     mem_dq_in <= 8'hEE;
      end
   end

   // Issue one access, starting at a falling edge; returns at the falling edge where ready is back.
   task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int busy;
      logic [DW-1:0] exp_b;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      cur_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      busy = 0;
      while (!req_ready) begin
         busy++;
         if (rsp_valid) check(0, "R5 early response", 1, 0);
         @(negedge clk);
      end
      if (wr) begin
         check(busy == E_FLT + E_DRV + E_REC, "R2 R8 write busy cycles", busy, E_FLT + E_DRV + E_REC);
         check(!rsp_valid, "R5 no response on write", rsp_valid, 0);
         ref_mem[a] = d;
      end else begin
         exp_b = ref_mem.exists(a) ? ref_mem[a] : blank_byte(a);
         check(busy == E_RD, "R2 read busy cycles", busy, E_RD);
         check(rsp_valid, "R5 response strobe", rsp_valid, 1);
         check(rsp_rdata == exp_b, "R5 read data", rsp_rdata, exp_b);
      end
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      check(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int n;
      logic [AW-1:0] pool [8];
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R3: reset state
      check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready && !rsp_valid,
            "R3 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111000);
      // R1: lockout with a pending write
      req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h5; req_wdata = 8'h33;
      rst_n = 1'b1;
      n = 0;
      while (!req_ready) begin
         @(posedge clk); @(negedge clk); n++;
      end
      req_valid = 1'b0;
      check(n == E_PU, "R1 lockout length", n, E_PU);
      check(!ce_seen_low, "R1 no select during lockout", ce_seen_low, 0);
      check(mem_ce_n && mem_oe_n && mem_we_n, "R3 idle strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      @(negedge clk);
      do_op(0, 21'h5, 8'h00);                 // R1 pending write had no effect
      // Directed corners
      do_op(1, '0, 8'hFF);
      do_op(1, {AW{1'b1}}, 8'h00);
      do_op(0, '0, 8'h00);
      do_op(0, {AW{1'b1}}, 8'h00);
      do_op(1, 21'h0ABCD, 8'hA5);             // R10 write then read same word back-to-back
      do_op(0, 21'h0ABCD, 8'h00);
      do_op(0, 21'h0ABCD, 8'h00);
      check(mem_ce_n && !mem_dq_oe, "R3 standby after access", {mem_ce_n, mem_dq_oe}, 2'b10);
      // Seeded random mix over a small address pool
      pool[0] = '0; pool[1] = {AW{1'b1}};
      for (int i = 2; i < 8; i++) pool[i] = AW'($urandom);
      for (int i = 0; i < 300; i++) begin
         do_op(1'($urandom % 2), pool[$urandom % 8], 8'($urandom));
         if (($urandom % 4) == 0) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule